// File: doc/BRIEF.md
# Correlator Measurement Packet Assembler

This block collects the latest in-phase and quadrature correlator results from a set of tracking channels (twelve by default). It turns them into one fixed-size byte packet per measurement period. Each channel may present a result on a strobe at any time. It may also signal the start of its satellite millisecond, together with a 6-bit time count. Results that arrive during one period are held in a shadow store. At the period boundary that store is moved into a transmit snapshot, so every packet reflects exactly one period.

The period comes from the operating mode and a rate-select bit. Tracking mode uses long periods (840 or 970 µs) and acquisition mode uses short ones (31 or 62 µs). Periods are counted in clock cycles through a cycles-per-microsecond parameter. Each channel also gets an 8-bit time tag. The tag is either a timestamp form or a sequence-number form, depending on the mode and on where the packet falls within that channel's satellite millisecond. The bytes leave over a valid/ready stream with a start-of-packet flag. If the consumer stalls past a period boundary, the new packet is discarded whole and a sticky overflow flag is raised.

Top module: `mpk_pkt_asm`

## Requirements
- R1: Every packet is 62 bytes, sent in this order: 2 header bytes, I of channels 0..11, Q of channels 0..11, then the 12 tag bytes (channel 0 first). Each 16-bit value is sent high byte first. `pkt_sop_o` is high with the first header byte.
- R2: Header byte 0 is 0xA5. Header byte 1 is {6'b0, mode, rate}, where mode is 1 for tracking and 0 for acquisition. Both bits are captured at the boundary that starts the packet.
- R3: With the stream never stalled, packets start every P cycles, where P = period_us × CYC_PER_US. The period is 31 µs (acquisition, rate 0), 62 µs (acquisition, rate 1), 840 µs (tracking, rate 0) or 970 µs (tracking, rate 1).
- R4: An I or Q slot whose channel gave no strobe during the period carries 0x8000.
- R5: In tracking mode a channel's tag is {2'b10, t}, where t is the time count latched at that channel's most recent epoch strobe (0 if there has been none).
- R6: In acquisition mode, the first packet whose period contains a channel's epoch strobe gives that channel the tag {2'b10, t}.
- R7: In acquisition mode, other packets give the tag {2'b00, s}. s is 2 in the packet after an epoch packet (and in the first packet after reset or after a configuration change), then rises by one per packet. It saturates at 32 for rate 0 and at 16 for rate 1.
- R8: A strobe during period n appears in the packet built at the end of period n, never earlier. If a channel strobes several times in one period, the last value wins. Strobes in the boundary cycle count for the next period.
- R9: A change of mode or rate restarts the period timer and sets every sequence counter back to 2. The next packet starts P_new cycles after the clock edge on which the change is seen.
- R10: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o` stays high and `pkt_data_o` stays unchanged.
- R11: If a packet is still being sent at a boundary, the new packet is dropped whole, `ovf_o` goes high and stays high until reset, and the packet in flight completes with all 62 bytes.
- R12: After reset `pkt_valid_o`, `pkt_sop_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 1 = tracking, 0 = acquisition |
| rate_i | input | 1 | Picks one of the two periods of the active mode |
| iq_stb_i | input | NCH | Per-channel result strobe |
| i_data_i | input | NCH*16 | Per-channel I value, channel c at bits [16c+15:16c] |
| q_data_i | input | NCH*16 | Per-channel Q value, same packing |
| epoch_stb_i | input | NCH | Per-channel satellite-millisecond epoch strobe |
| epoch_time_i | input | NCH*6 | Per-channel time count, channel c at bits [6c+5:6c] |
| pkt_data_o | output | 8 | Stream byte |
| pkt_valid_o | output | 1 | Byte valid |
| pkt_ready_i | input | 1 | Consumer ready |
| pkt_sop_o | output | 1 | First byte of a packet |
| ovf_o | output | 1 | Sticky overflow: a packet was dropped |

## Verification
The first byte of a packet is valid in the cycle after the boundary edge. Data strobed in a period is due in the next packet, so the bench starts stimulus right after a start-of-packet and checks the packet that follows the one in flight. After a configuration change, the next start-of-packet is due P_new + 1 cycles after the cycle in which the bench drove the change, and the bench compares that exact cycle number. Inputs are driven just after a rising edge and outputs are read on the falling edge, so each byte is seen once, in the cycle its handshake happens.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int unsigned SAMP_W      = 16;
  localparam int unsigned TIME_W      = 6;
  localparam logic [7:0]  SYNC_BYTE   = 8'hA5;
  localparam logic [15:0] EMPTY_SAMP  = 16'h8000;
  localparam logic [5:0]  SEQ_FIRST   = 6'd2;
  localparam logic [5:0]  SEQ_MAX_R0  = 6'd32;
  localparam logic [5:0]  SEQ_MAX_R1  = 6'd16;

  typedef enum logic [1:0] {
    TAG_STAMP = 2'b10,
    TAG_SEQ   = 2'b00
  } tag_kind_e;

  typedef struct packed {
    logic trk;
    logic rsel;
  } cfg_t;

  function automatic int unsigned pkt_len(input int unsigned nch);
    return 2 + 5 * nch;
  endfunction
endpackage

// File: rtl/mpk_timer.sv
module mpk_timer
  import mpk_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned US_ACQ_R0  = 31,
  parameter int unsigned US_ACQ_R1  = 62,
  parameter int unsigned US_TRK_R0  = 840,
  parameter int unsigned US_TRK_R1  = 970
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trk_i,
  input  logic rsel_i,
  output cfg_t cfg_o,
  output logic restart_o,
  output logic bnd_o
);
  localparam int unsigned P_A0  = US_ACQ_R0 * CYC_PER_US;
  localparam int unsigned P_A1  = US_ACQ_R1 * CYC_PER_US;
  localparam int unsigned P_T0  = US_TRK_R0 * CYC_PER_US;
  localparam int unsigned P_T1  = US_TRK_R1 * CYC_PER_US;
  localparam int unsigned P_MAX = (P_T1 > P_T0) ? P_T1 : P_T0;
  localparam int unsigned CW    = $clog2(P_MAX);

  cfg_t            cfg_q, cfg_d;
  logic [CW-1:0]   tmr_q, tmr_d, last;
  logic            chg;

  always_comb begin
    unique case ({cfg_q.trk, cfg_q.rsel})
      2'b00:   last = CW'(P_A0 - 1);
      2'b01:   last = CW'(P_A1 - 1);
      2'b10:   last = CW'(P_T0 - 1);
      default: last = CW'(P_T1 - 1);
    endcase
  end

  assign chg = (cfg_q.trk != trk_i) || (cfg_q.rsel != rsel_i);

  always_comb begin
    cfg_d = cfg_q;
    tmr_d = tmr_q;
    if (chg) begin
      cfg_d = '{trk: trk_i, rsel: rsel_i};
      tmr_d = '0;
    end else if (tmr_q == last) begin
      tmr_d = '0;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tmr_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      tmr_q <= tmr_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign restart_o = chg;
  assign bnd_o     = !chg && (tmr_q == last);

  // R9: a restart is never followed directly by a boundary
  a_r9_no_bnd_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !bnd_o);
  // R3: boundaries are isolated single-cycle events
  a_r3_bnd_single: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_o |=> !bnd_o);
endmodule

// File: rtl/mpk_chan.sv
module mpk_chan
  import mpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg_i,
  input  logic               bnd_i,
  input  logic               take_i,
  input  logic               restart_i,
  input  logic               stb_i,
  input  logic [SAMP_W-1:0]  i_i,
  input  logic [SAMP_W-1:0]  q_i,
  input  logic               ep_i,
  input  logic [TIME_W-1:0]  time_i,
  output logic [SAMP_W-1:0]  act_i_o,
  output logic [SAMP_W-1:0]  act_q_o,
  output logic [7:0]         tag_o
);
  logic [SAMP_W-1:0] sh_i_q, sh_i_d, sh_q_q, sh_q_d;
  logic              sh_v_q, sh_v_d;
  logic [TIME_W-1:0] tm_q, tm_d;
  logic              pend_q, pend_d;
  logic [5:0]        seq_q, seq_d, seq_max;
  logic [SAMP_W-1:0] act_i_q, act_i_d, act_q_q, act_q_d;
  logic [7:0]        tag_q, tag_d, tag_new;

  assign seq_max = cfg_i.rsel ? SEQ_MAX_R1 : SEQ_MAX_R0;

  always_comb begin
    if (cfg_i.trk || pend_q) tag_new = {TAG_STAMP, tm_q};
    else                     tag_new = {TAG_SEQ, seq_q};
  end

  always_comb begin
    sh_i_d  = sh_i_q;
    sh_q_d  = sh_q_q;
    sh_v_d  = sh_v_q;
    tm_d    = tm_q;
    pend_d  = pend_q;
    seq_d   = seq_q;
    act_i_d = act_i_q;
    act_q_d = act_q_q;
    tag_d   = tag_q;
    if (bnd_i) sh_v_d = 1'b0;
    if (stb_i) begin
      sh_i_d = i_i;
      sh_q_d = q_i;
      sh_v_d = 1'b1;
    end
    if (bnd_i)      pend_d = ep_i;
    else if (ep_i)  pend_d = 1'b1;
    if (ep_i)       tm_d   = time_i;
    if (restart_i) begin
      seq_d = SEQ_FIRST;
    end else if (bnd_i && !cfg_i.trk) begin
      if (pend_q)              seq_d = SEQ_FIRST;
      else if (seq_q < seq_max) seq_d = seq_q + 6'd1;
    end
    if (take_i) begin
      act_i_d = sh_v_q ? sh_i_q : EMPTY_SAMP;
      act_q_d = sh_v_q ? sh_q_q : EMPTY_SAMP;
      tag_d   = tag_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_i_q  <= '0;
      sh_q_q  <= '0;
      sh_v_q  <= 1'b0;
      tm_q    <= '0;
      pend_q  <= 1'b0;
      seq_q   <= SEQ_FIRST;
      act_i_q <= EMPTY_SAMP;
      act_q_q <= EMPTY_SAMP;
      tag_q   <= '0;
    end else begin
      sh_i_q  <= sh_i_d;
      sh_q_q  <= sh_q_d;
      sh_v_q  <= sh_v_d;
      tm_q    <= tm_d;
      pend_q  <= pend_d;
      seq_q   <= seq_d;
      act_i_q <= act_i_d;
      act_q_q <= act_q_d;
      tag_q   <= tag_d;
    end
  end

  assign act_i_o = act_i_q;
  assign act_q_o = act_q_q;
  assign tag_o   = tag_q;

  // R7: sequence counter never passes the limit of the active rate
  a_r7_seq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.trk |-> (seq_q >= SEQ_FIRST) && (seq_q <= seq_max));
  // R5: tracking snapshots always carry the timestamp form
  a_r5_trk_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cfg_i.trk) |=> tag_q[7:6] == 2'b10);
  // R8: the snapshot does not move between boundaries
  a_r8_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(act_i_q) && $stable(act_q_q));
endmodule

// File: rtl/mpk_tx.sv
module mpk_tx
  import mpk_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bnd_i,
  input  cfg_t                  cfg_i,
  input  logic [NCH*SAMP_W-1:0] act_i_i,
  input  logic [NCH*SAMP_W-1:0] act_q_i,
  input  logic [NCH*8-1:0]      tag_i,
  output logic                  take_o,
  output logic [7:0]            data_o,
  output logic                  valid_o,
  input  logic                  ready_i,
  output logic                  sop_o,
  output logic                  ovf_o
);
  localparam int unsigned PKT   = pkt_len(NCH);
  localparam int unsigned IW    = $clog2(PKT);
  localparam int unsigned I_B   = 2;
  localparam int unsigned Q_B   = I_B + 2 * NCH;
  localparam int unsigned T_B   = Q_B + 2 * NCH;

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  cfg_t          hdr_q, hdr_d;
  logic          ovf_q, ovf_d;
  logic          xfer;

  assign take_o = bnd_i && !busy_q;
  assign xfer   = busy_q && ready_i;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    hdr_d  = hdr_q;
    ovf_d  = ovf_q | (bnd_i && busy_q);
    if (take_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
      hdr_d  = cfg_i;
    end else if (xfer) begin
      if (idx_q == IW'(PKT - 1)) busy_d = 1'b0;
      else                       idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      hdr_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      hdr_q  <= hdr_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    int unsigned n;
    int unsigned k;
    logic [SAMP_W-1:0] w;
    n = int'(idx_q);
    w = '0;
    k = 0;
    if (n == 0) begin
      data_o = SYNC_BYTE;
    end else if (n == 1) begin
      data_o = {6'b0, hdr_q.trk, hdr_q.rsel};
    end else if (n < Q_B) begin
      k = n - I_B;
      w = act_i_i[(k >> 1) * SAMP_W +: SAMP_W];
      data_o = k[0] ? w[7:0] : w[15:8];
    end else if (n < T_B) begin
      k = n - Q_B;
      w = act_q_i[(k >> 1) * SAMP_W +: SAMP_W];
      data_o = k[0] ? w[7:0] : w[15:8];
    end else if (n < PKT) begin
      k = n - T_B;
      data_o = tag_i[k * 8 +: 8];
    end else begin
      data_o = '0;
    end
  end

  assign valid_o = busy_q;
  assign sop_o   = busy_q && (idx_q == '0);
  assign ovf_o   = ovf_q;

  // R10: a stalled byte holds still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o));
  // R11: overflow is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R1: a packet always opens with its start flag
  a_r1_sop_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> sop_o);
endmodule

// File: rtl/mpk_pkt_asm.sv
module mpk_pkt_asm
  import mpk_pkg::*;
#(
  parameter int unsigned NCH        = 12,
  parameter int unsigned CYC_PER_US = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_i,
  input  logic                  rate_i,
  input  logic [NCH-1:0]        iq_stb_i,
  input  logic [NCH*SAMP_W-1:0] i_data_i,
  input  logic [NCH*SAMP_W-1:0] q_data_i,
  input  logic [NCH-1:0]        epoch_stb_i,
  input  logic [NCH*TIME_W-1:0] epoch_time_i,
  output logic [7:0]            pkt_data_o,
  output logic                  pkt_valid_o,
  input  logic                  pkt_ready_i,
  output logic                  pkt_sop_o,
  output logic                  ovf_o
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  cfg_t                  cfg;
  logic                  restart, bnd, take;
  logic [NCH*SAMP_W-1:0] act_i, act_q;
  logic [NCH*8-1:0]      tags;

  mpk_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trk_i     (mode_i),
    .rsel_i    (rate_i),
    .cfg_o     (cfg),
    .restart_o (restart),
    .bnd_o     (bnd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mpk_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cfg_i     (cfg),
      .bnd_i     (bnd),
      .take_i    (take),
      .restart_i (restart),
      .stb_i     (iq_stb_i[g]),
      .i_i       (i_data_i[g*SAMP_W +: SAMP_W]),
      .q_i       (q_data_i[g*SAMP_W +: SAMP_W]),
      .ep_i      (epoch_stb_i[g]),
      .time_i    (epoch_time_i[g*TIME_W +: TIME_W]),
      .act_i_o   (act_i[g*SAMP_W +: SAMP_W]),
      .act_q_o   (act_q[g*SAMP_W +: SAMP_W]),
      .tag_o     (tags[g*8 +: 8])
    );
  end

  mpk_tx #(.NCH(NCH)) u_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bnd_i   (bnd),
    .cfg_i   (cfg),
    .act_i_i (act_i),
    .act_q_i (act_q),
    .tag_i   (tags),
    .take_o  (take),
    .data_o  (pkt_data_o),
    .valid_o (pkt_valid_o),
    .ready_i (pkt_ready_i),
    .sop_o   (pkt_sop_o),
    .ovf_o   (ovf_o)
  );

  // R12: nothing is offered while reset is held
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> !pkt_valid_o && !ovf_o);
endmodule

// File: tb/test_mpk_pkt_asm.sv
`timescale 1ns/1ps
module test_mpk_pkt_asm;
  localparam int NCH = 12;
  localparam int CPU = 4;
  localparam int P_A0 = 31 * CPU;
  localparam int P_A1 = 62 * CPU;
  localparam int P_T0 = 840 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, rate = 1'b0, ready = 1'b1;
  logic [NCH-1:0] iq_stb = '0, ep_stb = '0;
  logic [NCH*16-1:0] i_data = '0, q_data = '0;
  logic [NCH*6-1:0] ep_time = '0;
  logic [7:0] dout;
  logic valid, sop, ovf;

  always #4 clk = ~clk;

  mpk_pkt_asm #(.NCH(NCH), .CYC_PER_US(CPU)) i_mpk_pkt_asm (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rate_i(rate),
    .iq_stb_i(iq_stb), .i_data_i(i_data), .q_data_i(q_data),
    .epoch_stb_i(ep_stb), .epoch_time_i(ep_time),
    .pkt_data_o(dout), .pkt_valid_o(valid), .pkt_ready_i(ready),
    .pkt_sop_o(sop), .ovf_o(ovf));

  int checks = 0, fails = 0;
  int cyc = 0;
  int sop_cnt = 0, pkt_cnt = 0, partial = 0, bidx = 0;
  int sop_cyc = 0, sop_cyc_prev = 0;
  logic [7:0] cur [62];
  logic [7:0] got [62];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (sop) begin
        if (bidx != 0 && bidx != 62) partial++;
        bidx = 0;
        sop_cyc_prev = sop_cyc;
        sop_cyc = cyc;
        sop_cnt++;
      end
      if (bidx < 62) begin
        cur[bidx] = dout;
        bidx++;
        if (bidx == 62) begin
          got = cur;
          pkt_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int i_of(input int c); return {got[2+2*c], got[3+2*c]}; endfunction
  function automatic int q_of(input int c); return {got[26+2*c], got[27+2*c]}; endfunction
  function automatic int t_of(input int c); return got[50+c]; endfunction

  task automatic wait_sop();
    int s = sop_cnt;
    wait (sop_cnt != s);
  endtask

  task automatic next_pkt();
    int p = pkt_cnt;
    wait (pkt_cnt != p);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_iq(input int c, input logic [15:0] iv, input logic [15:0] qv);
    step();
    i_data[c*16 +: 16] = iv;
    q_data[c*16 +: 16] = qv;
    iq_stb[c] = 1'b1;
    step();
    iq_stb = '0;
  endtask

  task automatic pulse_ep(input int c, input logic [5:0] t);
    step();
    ep_time[c*6 +: 6] = t;
    ep_stb[c] = 1'b1;
    step();
    ep_stb = '0;
  endtask

  task automatic t_reset();
    #1;
    chk(!valid && !sop && !ovf, "R12", "outputs in reset", {valid, sop, ovf}, 0);
    repeat (4) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk(!valid && !ovf, "R12", "outputs after release", {valid, ovf}, 0);
  endtask

  task automatic t_empty();
    next_pkt();
    chk(got[0] == 8'hA5, "R2", "sync byte", got[0], 8'hA5);
    chk(got[1] == 8'h00, "R2", "acq rate0 header", got[1], 0);
    chk(i_of(0) == 16'h8000, "R4", "empty I ch0", i_of(0), 16'h8000);
    chk(q_of(11) == 16'h8000, "R4", "empty Q ch11", q_of(11), 16'h8000);
    chk(t_of(0) == 8'h02, "R7", "first seq tag", t_of(0), 8'h02);
    wait_sop();
    wait_sop();
    chk(sop_cyc - sop_cyc_prev == P_A0, "R3", "acq rate0 period",
        sop_cyc - sop_cyc_prev, P_A0);
  endtask

  task automatic t_capture();
    wait_sop();
    for (int c = 0; c < NCH; c++)
      if (c != 5) pulse_iq(c, 16'h1000 + 16'h0011 * c, 16'h2000 + c);
    pulse_iq(3, 16'hBEEF, 16'h1234);
    next_pkt();
    chk(i_of(0) == 16'h8000, "R8", "data not in packet in flight", i_of(0), 16'h8000);
    next_pkt();
    chk(i_of(0) == 16'h1000, "R1", "I ch0", i_of(0), 16'h1000);
    chk(i_of(11) == 16'h10BB, "R1", "I ch11", i_of(11), 16'h10BB);
    chk(q_of(0) == 16'h2000, "R1", "Q ch0", q_of(0), 16'h2000);
    chk(q_of(11) == 16'h200B, "R1", "Q ch11", q_of(11), 16'h200B);
    chk(i_of(3) == 16'hBEEF && q_of(3) == 16'h1234, "R8", "last strobe wins",
        i_of(3), 16'hBEEF);
    chk(i_of(5) == 16'h8000 && q_of(5) == 16'h8000, "R4", "silent ch5", i_of(5), 16'h8000);
    next_pkt();
    chk(i_of(0) == 16'h8000, "R4", "ch0 empty next period", i_of(0), 16'h8000);
  endtask

  task automatic t_acq_tags();
    wait_sop();
    pulse_ep(2, 6'h2A);
    pulse_ep(7, 6'h05);
    next_pkt();
    next_pkt();
    chk(t_of(2) == 8'hAA, "R6", "epoch stamp ch2", t_of(2), 8'hAA);
    chk(t_of(7) == 8'h85, "R6", "epoch stamp ch7", t_of(7), 8'h85);
    next_pkt();
    chk(t_of(2) == 8'h02, "R7", "seq 2 after stamp", t_of(2), 8'h02);
    next_pkt();
    chk(t_of(7) == 8'h03, "R7", "seq 3", t_of(7), 8'h03);
  endtask

  task automatic t_saturate(input logic [7:0] lim, input string tag);
    for (int n = 0; n < 36; n++) next_pkt();
    chk(t_of(0) == lim, "R7", tag, t_of(0), lim);
  endtask

  task automatic t_cfg_change();
    int c0;
    next_pkt();
    step();
    c0 = cyc;
    rate = 1'b1;
    wait_sop();
    chk(sop_cyc == c0 + 1 + P_A1, "R9", "restart to first sop", sop_cyc - c0, 1 + P_A1);
    next_pkt();
    chk(got[1] == 8'h01, "R2", "header after rate change", got[1], 8'h01);
    chk(t_of(0) == 8'h02, "R9", "seq reset on change", t_of(0), 8'h02);
    wait_sop();
    chk(sop_cyc - sop_cyc_prev == P_A1, "R3", "acq rate1 period",
        sop_cyc - sop_cyc_prev, P_A1);
  endtask

  task automatic t_stall();
    logic [7:0] d0;
    int p0;
    wait_sop();
    repeat (10) step();
    ready = 1'b0;
    @(negedge clk);
    d0 = dout;
    repeat (30) @(negedge clk);
    chk(valid && dout == d0, "R10", "stalled byte held", dout, d0);
    chk(!ovf, "R11", "no overflow before boundary", ovf, 0);
    repeat (300) @(negedge clk);
    chk(ovf, "R11", "overflow after stall past boundary", ovf, 1);
    p0 = pkt_cnt;
    step();
    ready = 1'b1;
    next_pkt();
    chk(got[0] == 8'hA5 && got[1] == 8'h01, "R11", "stalled packet complete", got[0], 8'hA5);
    next_pkt();
    chk(partial == 0, "R11", "no partial packet", partial, 0);
    chk(ovf, "R11", "overflow sticky", ovf, 1);
  endtask

  task automatic t_track();
    int s1;
    step();
    mode = 1'b1;
    rate = 1'b0;
    wait_sop();
    s1 = sop_cyc;
    pulse_ep(4, 6'h3F);
    next_pkt();
    chk(got[1] == 8'h02, "R2", "tracking header", got[1], 8'h02);
    next_pkt();
    chk(sop_cyc - s1 == P_T0, "R3", "tracking rate0 period", sop_cyc - s1, P_T0);
    chk(t_of(4) == 8'hBF, "R5", "tracking stamp ch4", t_of(4), 8'hBF);
    chk(t_of(0) == 8'h80, "R5", "tracking stamp ch0 no epoch", t_of(0), 8'h80);
    chk(t_of(2) == 8'hAA, "R5", "tracking keeps ch2 time", t_of(2), 8'hAA);
  endtask

  initial begin
    t_reset();
    t_empty();
    t_capture();
    t_acq_tags();
    t_saturate(8'h20, "saturate at 32 rate0");
    t_cfg_change();
    t_saturate(8'h10, "saturate at 16 rate1");
    t_stall();
    t_track();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule